// File: doc/BRIEF.md
# GPIO Port Data and Direction Registers

This block is the register side of a 32-pin general-purpose I/O port. Software sets each pin's direction through a direction register, sets output levels through an output-latch register, and reads pad levels back through a read-only pad status register. A pin whose direction bit is set drives its latched bit onto its pad output with its output enable raised. A pin whose direction bit is clear is an input. Its pad level is brought into the clock domain by a two-stage synchronizer and then read back.

The register interface is a single-cycle slave with valid, write, address and write-data inputs. Writes take effect at the clock edge that accepts them. Read data is registered and is presented in the cycle after the read is accepted. Reading the output-latch register gives a per-bit blend: output pins return the latched value and input pins return the synchronized pad level.

Top module: `gpio_port`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the output latches, the direction bits, the synchronizer stages and the read data. All pins start as inputs with pad_oe and pad_out at zero.
- R2: pad_out equals the output latches ANDed with the direction bits. A write to offset 0x00 changes pad_out from the clock edge that accepts it.
- R3: pad_oe equals the direction bits. A write to offset 0x04 changes pad_oe from the accepting edge, and a read of 0x04 returns the direction bits.
- R4: A read of offset 0x00 returns (latches AND direction) OR (synchronized pads AND NOT direction), chosen bit by bit.
- R5: A read of offset 0x08 returns the synchronized pads AND NOT direction, so bits of output pins read 0.
- R6: A write to offset 0x08 changes no latch, no direction bit and no pad output.
- R7: Only word-aligned accesses to 0x00, 0x04 and 0x08 are mapped. Any other address, misaligned ones included, reads as zero and is ignored on write.
- R8: A pad level change becomes visible to reads after two clock edges. A read accepted at the first or second edge after the change still returns the old level, and a read accepted at the third edge returns the new level.
- R9: bus_rdata holds the result of the read accepted at the previous edge, and is zero in any cycle that follows an edge with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request, accepted at the next rising edge |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output levels, gated by direction |
| pad_oe | output | 32 | Per-pin output enable |

## Verification
pad_out and pad_oe change at the edge that accepts a write, so the bench samples them at the falling edge right after that write. Read data is due one edge after the read is accepted, and the bench samples it at the following falling edge. A pad change needs two edges to reach the readable pin state, so a read-back check first waits three falling edges after a pad change. The synchronizer test instead issues reads back to back from the moment of the change and expects old, old, then new. The bound checker checks these same one-edge relations with |=> properties, and checks the two-edge synchronizer path only after a cycle counter shows that two edges have passed since reset.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    SEL_LATCH  = 2'd0,
    SEL_DIR    = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam logic [31:0] OFS_LATCH  = 32'h0000_0000;
  localparam logic [31:0] OFS_DIR    = 32'h0000_0004;
  localparam logic [31:0] OFS_STATUS = 32'h0000_0008;

  // Word-aligned decode; anything else selects nothing.
  function automatic reg_sel_e decode_sel(input logic [31:0] addr);
    reg_sel_e s;
    if (addr[1:0] != 2'b00) begin
      s = SEL_NONE;
    end else begin
      case (addr)
        OFS_LATCH:  s = SEL_LATCH;
        OFS_DIR:    s = SEL_DIR;
        OFS_STATUS: s = SEL_STATUS;
        default:    s = SEL_NONE;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int PINS   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_latch_evt,
  input  logic              wr_dir_evt,
  input  logic [DATA_W-1:0] wdata,
  output logic [PINS-1:0]   latch_q,
  output logic [PINS-1:0]   dir_q
);

  logic [PINS-1:0] wr_bits;
  assign wr_bits = wdata[PINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (wr_latch_evt) begin
      latch_q <= wr_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (wr_dir_evt) begin
      dir_q <= wr_bits;
    end
  end

endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux
  import gpio_port_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_evt,
  input  reg_sel_e          sel,
  input  logic [PINS-1:0]   latch_q,
  input  logic [PINS-1:0]   dir_q,
  input  logic [PINS-1:0]   pin_state,
  output logic [DATA_W-1:0] rdata
);

  function automatic logic [PINS-1:0] blend_view(
    input logic [PINS-1:0] lat,
    input logic [PINS-1:0] dir,
    input logic [PINS-1:0] pins
  );
    return (lat & dir) | (pins & ~dir);
  endfunction

  function automatic logic [PINS-1:0] input_view(
    input logic [PINS-1:0] dir,
    input logic [PINS-1:0] pins
  );
    return pins & ~dir;
  endfunction

  logic [PINS-1:0]   latch_view;
  logic [PINS-1:0]   status_view;
  logic [DATA_W-1:0] rd_next;

  assign latch_view  = blend_view(latch_q, dir_q, pin_state);
  assign status_view = input_view(dir_q, pin_state);

  always_comb begin
    rd_next = '0;
    if (rd_evt) begin
      case (sel)
        SEL_LATCH:  rd_next = DATA_W'(latch_view);
        SEL_DIR:    rd_next = DATA_W'(dir_q);
        SEL_STATUS: rd_next = DATA_W'(status_view);
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_next;
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);

  localparam int ADDR_EXT_W = 32;

  logic [ADDR_EXT_W-1:0] addr_ext;
  reg_sel_e              sel;
  logic                  wr_latch_evt;
  logic                  wr_dir_evt;
  logic                  rd_evt;
  logic [PINS-1:0]       latch_q;
  logic [PINS-1:0]       dir_q;
  logic [PINS-1:0]       pin_state;

  assign addr_ext     = ADDR_EXT_W'(bus_addr);
  assign sel          = decode_sel(addr_ext);
  assign wr_latch_evt = bus_valid && bus_write && (sel == SEL_LATCH);
  assign wr_dir_evt   = bus_valid && bus_write && (sel == SEL_DIR);
  assign rd_evt       = bus_valid && !bus_write;

  gpio_port_sync #(
    .W      (PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_state)
  );

  gpio_port_regs #(
    .PINS   (PINS),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_latch_evt (wr_latch_evt),
    .wr_dir_evt   (wr_dir_evt),
    .wdata        (bus_wdata),
    .latch_q      (latch_q),
    .dir_q        (dir_q)
  );

  gpio_port_rdmux #(
    .PINS   (PINS),
    .DATA_W (DATA_W)
  ) u_rdmux (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_evt    (rd_evt),
    .sel       (sel),
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .pin_state (pin_state),
    .rdata     (bus_rdata)
  );

  assign pad_oe  = dir_q;
  assign pad_out = latch_q & dir_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int PINS   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [PINS-1:0]   pad_in,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   pad_oe,
  input logic [PINS-1:0]   pin_state
);

  logic at_latch, at_dir, at_status, unmapped;
  assign at_latch  = (bus_addr == ADDR_W'(0));
  assign at_dir    = (bus_addr == ADDR_W'(4));
  assign at_status = (bus_addr == ADDR_W'(8));
  assign unmapped  = !(at_latch || at_dir || at_status);

  // Edges seen since reset, saturating at 3.
  logic [1:0] edges_since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     edges_since_rst <= 2'd0;
    else if (edges_since_rst != 2'd3) edges_since_rst <= edges_since_rst + 2'd1;
  end

  assert_latch_write_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && at_latch) |=> (pad_out == ($past(bus_wdata[PINS-1:0]) & pad_oe)));

  assert_dir_write_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && at_dir) |=> (pad_oe == $past(bus_wdata[PINS-1:0])));

  assert_status_outputs_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && at_status) |=> ((bus_rdata[PINS-1:0] & pad_oe) == '0));

  assert_status_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && at_status) |=> ($stable(pad_oe) && $stable(pad_out)));

  assert_unmapped_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && unmapped) |=> ($stable(pad_oe) && $stable(pad_out)));

  assert_unmapped_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && unmapped) |=> (bus_rdata == '0));

  assert_sync_two_edges_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_since_rst == 2'd3) |-> (pin_state == $past(pad_in, 2)));

  assert_idle_rdata_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> (bus_rdata == '0));

endmodule

bind gpio_port gpio_port_chk #(
  .PINS   (PINS),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pin_state (pin_state)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
  localparam int PINS = 32;
  localparam int DW   = 32;
  localparam int AW   = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [PINS-1:0] pad_in = '0;
  logic [PINS-1:0] pad_out;
  logic [PINS-1:0] pad_oe;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  gpio_port i_gpio_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r, r1, r2, r3, g, d, p;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 pad_oe in reset", pad_oe, 32'h0);
    check("R1 pad_out in reset", pad_out, 32'h0);
    check("R1 rdata in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    rd(8'h04, r); check("R1 dir after reset", r, 32'h0);
    rd(8'h00, r); check("R1 latch view after reset", r, 32'h0);

    // R2 R3 R4 R5: sweep of direction, latch and pad patterns
    for (int k = 0; k < 40; k++) begin
      g = (k * 32'h9E37_79B9) ^ (32'h1 << (k % 32));
      d = ~(k * 32'h85EB_CA6B);
      p = (k * 32'hC2B2_AE35) ^ 32'h5A5A_0F0F;
      if (k == 0) g = 32'h0;
      if (k == 1) g = 32'hFFFF_FFFF;
      wr(8'h04, g);
      check("R3 pad_oe after dir write", pad_oe, g);
      wr(8'h00, d);
      check("R2 pad_out after latch write", pad_out, d & g);
      pad_in = p;
      repeat (3) @(negedge clk);
      rd(8'h00, r); check("R4 blended latch read", r, (d & g) | (p & ~g));
      rd(8'h08, r); check("R5 status read", r, p & ~g);
      rd(8'h04, r); check("R3 dir read", r, g);
    end

    // R4: walking single output pin against all-ones and all-zero pads
    for (int i = 0; i < PINS; i++) begin
      wr(8'h04, 32'h1 << i);
      wr(8'h00, 32'hFFFF_FFFF);
      pad_in = '0;
      repeat (3) @(negedge clk);
      rd(8'h00, r); check("R4 walk output high", r, 32'h1 << i);
      wr(8'h00, 32'h0);
      pad_in = '1;
      repeat (3) @(negedge clk);
      rd(8'h00, r); check("R4 walk input high", r, ~(32'h1 << i));
    end

    // R6: write to status offset is ignored
    wr(8'h04, 32'h0000_FFFF);
    wr(8'h00, 32'h1234_5678);
    wr(8'h08, 32'hFFFF_FFFF);
    check("R6 pad_oe after status write", pad_oe, 32'h0000_FFFF);
    check("R6 pad_out after status write", pad_out, 32'h0000_5678);
    rd(8'h04, r); check("R6 dir after status write", r, 32'h0000_FFFF);

    // R7: unmapped and misaligned accesses
    rd(8'h01, r); check("R7 misaligned read", r, 32'h0);
    rd(8'h0C, r); check("R7 unmapped read", r, 32'h0);
    rd(8'h06, r); check("R7 misaligned read in map", r, 32'h0);
    wr(8'h05, 32'hFFFF_FFFF);
    wr(8'h01, 32'h0);
    wr(8'h10, 32'hAAAA_AAAA);
    check("R7 pad_oe after ignored writes", pad_oe, 32'h0000_FFFF);
    check("R7 pad_out after ignored writes", pad_out, 32'h0000_5678);
    rd(8'h04, r); check("R7 dir after ignored writes", r, 32'h0000_FFFF);

    // R8: synchronizer latency, reads back to back from the pad change
    wr(8'h04, 32'h0);
    pad_in = '0;
    repeat (3) @(negedge clk);
    @(negedge clk);
    pad_in = 32'hC3C3_3C3C;
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'h08;
    @(negedge clk); r1 = bus_rdata;
    @(negedge clk); r2 = bus_rdata;
    @(negedge clk); r3 = bus_rdata;
    bus_valid = 1'b0;
    check("R8 first read old level", r1, 32'h0);
    check("R8 second read old level", r2, 32'h0);
    check("R8 third read new level", r3, 32'hC3C3_3C3C);

    // R9: rdata returns to zero after an idle edge
    @(negedge clk);
    check("R9 rdata idle zero", bus_rdata, 32'h0);

    // R1: reset in the middle of operation
    wr(8'h04, 32'hF0F0_F0F0);
    wr(8'h00, 32'hFFFF_FFFF);
    @(negedge clk);
    rst_n = 1'b0;
    pad_in = '0;
    #1;
    check("R1 pad_oe on mid reset", pad_oe, 32'h0);
    check("R1 pad_out on mid reset", pad_out, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(8'h00, r); check("R1 latch view after mid reset", r, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule